// File: doc/BRIEF.md
# Virtual Running Priority Calculator

This block works out the running priority of a virtual CPU interface from the state of its active-priority bitmaps. The bitmaps come in two banks, one per interrupt group. Each bank is a set of 32-bit words placed side by side on one input bus. A set bit means that a priority group currently has an active interrupt. The block merges the two banks, finds the numerically lowest set bit across the implemented words, and turns that bit index back into an 8-bit priority value. The bit index is scaled by the minimum binary point that follows from the number of implemented preemption bits.

The caller raises a one-cycle read strobe. On the next cycle the block presents the computed priority together with a one-cycle valid pulse. The priority output then holds that value until the next strobe. If no bit is set in any implemented word, the result is the idle priority 0xFF. The logic that sets, clears or writes the bitmaps lies outside this block.

Top module: `run_prio_calc`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `runPrio` reads 0xFF and `runValid` reads 0.
- R2: `runValid` is 1 in exactly the cycle after a clock edge that samples `rdStrobe` high, and 0 in every other cycle.
- R3: `runPrio` changes only at an edge that samples `rdStrobe` high. Changes on the bitmap or preemption inputs with no strobe leave it unchanged.
- R4: The search operates on the bitwise OR of the two banks. A bit set in either bank counts as set.
- R5: Word w occupies bus bits [32w+31:32w]. The search picks the lowest-numbered nonzero implemented word and, within it, the least significant set bit. This gives bit index = 32*w + bit position.
- R6: The result equals the bit index shifted left by (8 - p), where p is the effective preemption bit count. This shift equals the minimum binary point (7 - p) plus one. The result is truncated to 8 bits.
- R7: When no bit is set in any implemented word of either bank, the result is 0xFF.
- R8: Only 2^(p-5) words (1, 2 or 4) are searched. Set bits in higher words have no effect on the result.
- R9: A `preBits` value below 5 acts as 5, and a value above 7 acts as 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grp0Bits | input | 128 | Group 0 active-priority bitmap, word w at bits [32w+31:32w] |
| grp1Bits | input | 128 | Group 1 active-priority bitmap, same layout |
| preBits | input | 3 | Number of implemented preemption bits |
| rdStrobe | input | 1 | Request a new running-priority evaluation |
| runPrio | output | 8 | Registered running priority |
| runValid | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The stimulus uses sparse random bitmaps, so the first set bit lands at varied word and bit positions. These patterns separate a correct lowest-bit search from a highest-bit or wrong-word search. Directed cases place a bit in one bank only, which exposes a missing OR merge. Other directed cases set bits only above the implemented word count, which must yield 0xFF and shows whether the word limit is honoured. Every `preBits` value from 0 to 7 is applied, which checks the shift amount and the clamping. Input changes made with no strobe show that the output holds.

// File: rtl/rprio_pkg.sv
package rprio_pkg;
  parameter int WORD_W    = 32;
  parameter int PRIO_W    = 8;
  parameter int PRE_W     = 3;
  localparam int MIN_PRE   = $clog2(WORD_W);
  localparam int MAX_PRE   = PRIO_W - 1;
  localparam int MAX_WORDS = 2 ** (MAX_PRE - MIN_PRE);
  localparam int BUS_W     = MAX_WORDS * WORD_W;
  localparam int POS_W     = $clog2(WORD_W);
  localparam int IDX_W     = $clog2(BUS_W);
  localparam int SH_W      = $clog2(PRIO_W) + 1;
  localparam int WIDX_W    = $clog2(MAX_WORDS) + 1;

  typedef struct packed {
    logic                 load;
    logic [MAX_WORDS-1:0] wordEn;
    logic [SH_W-1:0]      shiftAmt;
  } dpCtrl_t;
endpackage

// File: rtl/rprio_ctrl.sv
module rprio_ctrl
  import rprio_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [PRE_W-1:0] preBits,
  input  logic             rdStrobe,
  output dpCtrl_t          dpCtrl,
  output logic             runValid
);
  localparam logic [PRE_W-1:0] MIN_PRE_V = PRE_W'(MIN_PRE);
  localparam logic [PRE_W-1:0] MAX_PRE_V = PRE_W'(MAX_PRE);

  logic [PRE_W-1:0] preEff;
  logic [PRE_W-1:0] span;

  // Clamp the preemption bit count into the supported range
  always_comb begin
    if (preBits < MIN_PRE_V)      preEff = MIN_PRE_V;
    else if (preBits > MAX_PRE_V) preEff = MAX_PRE_V;
    else                          preEff = preBits;
  end

  assign span = preEff - MIN_PRE_V;

  // Word i is searched when i < 2^span
  for (genvar i = 0; i < MAX_WORDS; i++) begin : g_wordEn
    localparam logic [WIDX_W-1:0] I_V = WIDX_W'(i);
    assign dpCtrl.wordEn[i] = ((I_V >> span) == '0);
  end

  assign dpCtrl.shiftAmt = SH_W'(PRIO_W) - SH_W'(preEff);
  assign dpCtrl.load     = rdStrobe;

  always_ff @(posedge clk) begin
    if (!rstN) runValid <= 1'b0;
    else       runValid <= rdStrobe;
  end
endmodule

// File: rtl/rprio_datapath.sv
module rprio_datapath
  import rprio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  grp0Bits,
  input  logic [BUS_W-1:0]  grp1Bits,
  input  dpCtrl_t           dpCtrl,
  output logic [PRIO_W-1:0] runPrio
);
  logic [MAX_WORDS-1:0] wordHit;
  logic [POS_W-1:0]     wordPos [MAX_WORDS];

  for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] merged;
    assign merged     = (grp0Bits[w*WORD_W +: WORD_W] | grp1Bits[w*WORD_W +: WORD_W])
                        & {WORD_W{dpCtrl.wordEn[w]}};
    assign wordHit[w] = |merged;

    // Least significant set bit of the merged word
    always_comb begin
      wordPos[w] = '0;
      for (int b = WORD_W - 1; b >= 0; b--) begin
        if (merged[b]) wordPos[w] = POS_W'(b);
      end
    end
  end

  logic             found;
  logic [IDX_W-1:0] bitIdx;

  // The lowest nonzero word wins
  always_comb begin
    found  = 1'b0;
    bitIdx = '0;
    for (int w = MAX_WORDS - 1; w >= 0; w--) begin
      if (wordHit[w]) begin
        found  = 1'b1;
        bitIdx = IDX_W'(w * WORD_W) + IDX_W'(wordPos[w]);
      end
    end
  end

  logic [PRIO_W+IDX_W-1:0] wide;
  logic [PRIO_W-1:0]       nextPrio;

  assign wide     = {{PRIO_W{1'b0}}, bitIdx} << dpCtrl.shiftAmt;
  assign nextPrio = found ? wide[PRIO_W-1:0] : {PRIO_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rstN)            runPrio <= {PRIO_W{1'b1}};
    else if (dpCtrl.load) runPrio <= nextPrio;
  end
endmodule

// File: rtl/run_prio_calc.sv
module run_prio_calc
  import rprio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_W-1:0]  grp0Bits,
  input  logic [BUS_W-1:0]  grp1Bits,
  input  logic [PRE_W-1:0]  preBits,
  input  logic              rdStrobe,
  output logic [PRIO_W-1:0] runPrio,
  output logic              runValid
);
  dpCtrl_t dpCtrl;

  rprio_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .preBits  (preBits),
    .rdStrobe (rdStrobe),
    .dpCtrl   (dpCtrl),
    .runValid (runValid)
  );

  rprio_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .grp0Bits (grp0Bits),
    .grp1Bits (grp1Bits),
    .dpCtrl   (dpCtrl),
    .runPrio  (runPrio)
  );
endmodule

// File: rtl/run_prio_calc_checker.sv
module run_prio_calc_checker
  import rprio_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [BUS_W-1:0]  grp0Bits,
  input logic [BUS_W-1:0]  grp1Bits,
  input logic [PRE_W-1:0]  preBits,
  input logic              rdStrobe,
  input logic [PRIO_W-1:0] runPrio,
  input logic              runValid
);
  p_valid_after_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> runValid);

  p_no_valid_without_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> !runValid);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> $stable(runPrio));

  p_idle_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && ((grp0Bits | grp1Bits) == '0)) |=> (runPrio == {PRIO_W{1'b1}}));

  p_bit_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && (grp0Bits[0] || grp1Bits[0])) |=> (runPrio == '0));

  p_scale_pre5_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && preBits == PRE_W'(5) &&
     ((grp0Bits[WORD_W-1:0] | grp1Bits[WORD_W-1:0]) != '0)) |=> (runPrio[2:0] == 3'b000));
endmodule

bind run_prio_calc run_prio_calc_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .grp0Bits (grp0Bits),
  .grp1Bits (grp1Bits),
  .preBits  (preBits),
  .rdStrobe (rdStrobe),
  .runPrio  (runPrio),
  .runValid (runValid)
);

// File: tb/tb_run_prio_calc.sv
module tb_run_prio_calc;
  logic         clk = 1'b0;
  logic         rstN;
  logic [127:0] grp0Bits;
  logic [127:0] grp1Bits;
  logic [2:0]   preBits;
  logic         rdStrobe;
  logic [7:0]   runPrio;
  logic         runValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  run_prio_calc dut (
    .clk(clk), .rstN(rstN), .grp0Bits(grp0Bits), .grp1Bits(grp1Bits),
    .preBits(preBits), .rdStrobe(rdStrobe), .runPrio(runPrio), .runValid(runValid)
  );

  function automatic logic [7:0] refPrio(input logic [127:0] a, input logic [127:0] b,
                                         input int pre);
    int p = (pre < 5) ? 5 : ((pre > 7) ? 7 : pre);
    int nw = 1 << (p - 5);
    logic [127:0] m = a | b;
    for (int i = 0; i < nw * 32; i++) begin
      if (m[i]) return 8'((i << (8 - p)) & 255);
    end
    return 8'hFF;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Strobe a read and check valid pulse plus value one cycle later
  task automatic doRead(input logic [127:0] a, input logic [127:0] b, input logic [2:0] p,
                        input string req);
    @(negedge clk);
    grp0Bits = a; grp1Bits = b; preBits = p; rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    check({req, " R2 valid"}, 32'(runValid), 32'd1);
    check(req, 32'(runPrio), 32'(refPrio(a, b, int'(p))));
  endtask

  function automatic logic [127:0] sparse();
    logic [127:0] v;
    for (int k = 0; k < 4; k++)
      v[k*32 +: 32] = $urandom & $urandom & $urandom & (($urandom % 3 == 0) ? 32'h0 : 32'hFFFF_FFFF);
    return v;
  endfunction

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    rstN = 1'b0; grp0Bits = '0; grp1Bits = '0; preBits = 3'd7; rdStrobe = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 prio", 32'(runPrio), 32'hFF);
    check("R1 valid", 32'(runValid), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 prio after", 32'(runPrio), 32'hFF);
    check("R1 valid after", 32'(runValid), 32'd0);

    // Directed corner cases
    doRead('0, '0, 3'd7, "R7 empty");
    doRead(128'h1, '0, 3'd7, "R5 bit0 grp0");
    doRead('0, 128'h1 << 45, 3'd7, "R4 grp1 only");
    doRead(128'h1 << 70, 128'h1 << 33, 3'd7, "R4 merge lowest");
    doRead(128'h1 << 127, '0, 3'd7, "R6 top bit");
    doRead(128'h1 << 31, '0, 3'd5, "R6 pre5 scale");
    doRead(128'h1 << 63, '0, 3'd6, "R6 pre6 scale");
    doRead(128'h1 << 40, '0, 3'd5, "R8 above word count pre5");
    doRead(128'h1 << 100, 128'h1 << 64, 3'd6, "R8 above word count pre6");
    doRead(128'h1 << 96, '0, 3'd7, "R8 word3 used pre7");
    doRead(128'h1 << 12, '0, 3'd0, "R9 clamp low");
    doRead(128'h1 << 50, '0, 3'd2, "R9 clamp low ignores word1");
    doRead(128'h1 << 31, '0, 3'd4, "R9 clamp pre4");

    // Hold: change inputs with no strobe
    doRead(128'h1 << 9, '0, 3'd7, "R3 setup");
    @(negedge clk);
    grp0Bits = 128'h1; preBits = 3'd5;
    check("R2 no valid", 32'(runValid), 32'd0);
    @(negedge clk);
    check("R3 hold", 32'(runPrio), 32'(refPrio(128'h1 << 9, '0, 7)));
    check("R2 no valid 2", 32'(runValid), 32'd0);

    // Random
    for (int n = 0; n < 400; n++) begin
      doRead(sparse(), sparse(), 3'($urandom % 8), "R5 R6 R8 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule